// File: doc/BRIEF.md
# Region-Selecting Level-Shifted PWM Generator

This block produces the switch drive signals for one phase of a three-cell cascaded H-bridge whose cells can be rewired after a switch fails. It runs its own triangular carrier counter and compares it against a signed modulating sample to form three positive-band and three negative-band comparisons. It also sorts the sample into one of six amplitude bands, three positive and three negative. Depending on the active wiring code it routes either a comparison or a fixed 0/1 level to each of the six bridge arms. With all cells healthy the output is classic level-shifted PWM. After a first fault, a two-source cell conducts while a single cell fills in the intermediate steps. With only one combined cell left, the block falls back to phase-shifted PWM.

Arm `2k` is the left arm of cell `k` and arm `2k+1` is its right arm. A left arm at 1 ties the cell's output terminal to its positive rail. A right arm at 1 ties the return terminal to the negative rail. The cell's contribution, in units of its own source voltage, is therefore `left + right - 1`. Each arm drives its two switches as a complementary pair (`gate_hi`, `gate_lo`). A new sample and a new wiring code are taken only at the carrier peak, so a change never lands in the middle of a carrier half-period. With the default carrier amplitude of 5000 and a 50 MHz clock, the carrier period is 10000 cycles, which gives a 5 kHz switching rate.

Top module: `lspwm_region_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gate_hi` is all 0 and `gate_lo` is all 1. The carrier restarts at 0 counting up, the held sample is 0 and the held wiring code is healthy (0).
- R2: The carrier counts 0,1,…,AC then AC−1,…,0 and repeats, with a period of 2·AC cycles. `mod_in` and `cfg_in` are copied into the held sample and held code only in a cycle in which the carrier equals AC. At every other time their values have no effect.
- R3: The held sample m falls into band P_i when (i−1)·AC < m ≤ i·AC, or into band N_i when −i·AC ≤ m < −(i−1)·AC (i = 1..3). m = 0 falls into N1. Values above 3·AC are treated as P3, and values below −3·AC are treated as N3.
- R4: Code 0 (healthy). With carrier c, the layer k comparisons (k = 1..3) are up_k = (m > (k−1)·AC + c) and dn_k = (m > −((k−1)·AC + c)). Cell k−1 left arm = up_k and right arm = dn_k.
- R5: Code 1 (mixed). Cell 0 is the two-source module and cell 1 is bypassed, with both of its arms at 0. The cell 0 left arm is 1 in P bands and 0 in N bands. Its right arm is 0,1,1 in P1..P3 and 1,0,0 in N1..N3.
- R6: Code 1 (mixed). Cell 2 is the single module. Its left arm is up_i in band P_i and 0,1,0 in N1..N3. Its right arm is 1,0,1 in P1..P3 and dn_i in band N_i.
- R7: Code 2 (substitute). Arms are as for code 1, except that the cell 0 right arm is 0, the cell 1 left arm is 1, and the cell 1 right arm carries the value the cell 0 right arm has under code 1.
- R8: Code 3 (triple). With t = 6·c − 3·AC, the cell 0 left arm is (m > t) and its right arm is (m > −t). All arms of cells 1 and 2 are 0.
- R9: `gate_hi` is registered. In each cycle it shows the arm values formed in the previous cycle from that cycle's carrier value, held sample and held code.
- R10: `gate_lo` is the bitwise complement of `gate_hi` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_in | input | MOD_W | Signed modulating sample in carrier units |
| cfg_in | input | 2 | Wiring code: 0 healthy, 1 mixed, 2 substitute, 3 triple |
| gate_hi | output | 6 | Arm signals, bit 2k = cell k left, bit 2k+1 = cell k right |
| gate_lo | output | 6 | Complement of gate_hi for the lower switch of each arm |

## Verification
The hardest situations to reach from the ports are twofold. The first is a sample change that arrives between carrier peaks and must leave the arms untouched. The second is a sample lying exactly on a band edge while the carrier sits at 0 or at AC, where every strict comparison flips. The stimulus holds each input for a number of cycles that is not a multiple of the carrier period, so changes drift across every carrier phase. It then steps through values equal to each band edge, one unit to either side of it, and far beyond the saturation limit, under every wiring code. A cycle-accurate behavioural model of the carrier, the peak capture and the band tables predicts every arm on every clock.

// File: rtl/lspwm_pkg.sv
package lspwm_pkg;

    localparam int NUM_CELLS  = 3;
    localparam int NUM_LAYERS = 3;
    localparam int NUM_ARMS   = 2 * NUM_CELLS;

    // cell roles once the phase has been rewired
    localparam int CELL_DBL = 0;
    localparam int CELL_BYP = 1;
    localparam int CELL_SGL = 2;

    typedef enum logic [1:0] {
        CFG_HEALTHY = 2'd0,
        CFG_MIXED   = 2'd1,
        CFG_SUBST   = 2'd2,
        CFG_TRIPLE  = 2'd3
    } cfg_e;

    typedef enum logic [2:0] {
        BAND_P1 = 3'd0,
        BAND_P2 = 3'd1,
        BAND_P3 = 3'd2,
        BAND_N1 = 3'd3,
        BAND_N2 = 3'd4,
        BAND_N3 = 3'd5
    } band_e;

    function automatic logic band_is_pos(band_e b);
        return (b == BAND_P1) || (b == BAND_P2) || (b == BAND_P3);
    endfunction

    function automatic logic [1:0] band_depth(band_e b);
        logic [1:0] d;
        case (b)
            BAND_P1, BAND_N1: d = 2'd0;
            BAND_P2, BAND_N2: d = 2'd1;
            default:          d = 2'd2;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lspwm_carrier.sv
module lspwm_carrier #(
    parameter int AC = 5000,
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] car_o,
    output logic          peak_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          down;
    } car_t;

    car_t cr_d, cr_q;

    always_comb begin
        cr_d = cr_q;
        if (!cr_q.down) begin
            cr_d.cnt = cr_q.cnt + 1'b1;
            if (cr_q.cnt == CW'(AC - 1)) begin
                cr_d.down = 1'b1;
            end
        end else begin
            cr_d.cnt = cr_q.cnt - 1'b1;
            if (cr_q.cnt == CW'(1)) begin
                cr_d.down = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q <= '0;
        end else begin
            cr_q <= cr_d;
        end
    end

    assign car_o  = cr_q.cnt;
    assign peak_o = (cr_q.cnt == CW'(AC));

    // R2: carrier never leaves 0..AC
    assert_carrier_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cr_q.cnt <= CW'(AC));

    // R2: rising half steps by one
    assert_carrier_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cr_q.down && cr_q.cnt != CW'(AC)) |=> (cr_q.cnt == $past(cr_q.cnt) + 1'b1));

    // R2: the peak turns the count around
    assert_carrier_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        peak_o |=> (cr_q.cnt == CW'(AC - 1)));

endmodule

// File: rtl/lspwm_layer_cmp.sv
module lspwm_layer_cmp #(
    parameter int AC = 5000,
    parameter int CW = 13,
    parameter int EW = 33,
    parameter int NL = 3
) (
    input  logic                 [CW-1:0] car_i,
    input  logic signed          [EW-1:0] m_i,
    output logic                 [NL-1:0] up_o,
    output logic                 [NL-1:0] dn_o,
    output logic                          ps_l_o,
    output logic                          ps_r_o
);

    localparam logic signed [EW-1:0] SPAN3 = $signed(EW'(NL * AC));

    logic signed [EW-1:0] car_s;
    logic signed [EW-1:0] tri_s;

    assign car_s = $signed(EW'(car_i));

    // one stacked carrier per layer, mirrored below zero
    for (genvar k = 0; k < NL; k++) begin : g_layer
        logic signed [EW-1:0] off_s;
        assign off_s   = car_s + $signed(EW'(k * AC));
        assign up_o[k] = (m_i > off_s);
        assign dn_o[k] = (m_i > -off_s);
    end

    // full-span carrier for the phase-shifted fallback: 2*NL*c - NL*AC
    assign tri_s  = (car_s <<< 1) + (car_s <<< 2) - SPAN3;
    assign ps_l_o = (m_i > tri_s);
    assign ps_r_o = (m_i > -tri_s);

endmodule

// File: rtl/lspwm_band_cls.sv
module lspwm_band_cls
    import lspwm_pkg::*;
#(
    parameter int AC = 5000,
    parameter int EW = 33
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [EW-1:0] m_i,
    output band_e                band_o
);

    localparam logic signed [EW-1:0] ZERO = '0;
    localparam logic signed [EW-1:0] LIM1 = $signed(EW'(AC));
    localparam logic signed [EW-1:0] LIM2 = $signed(EW'(2 * AC));

    always_comb begin
        if (m_i > LIM2) begin
            band_o = BAND_P3;
        end else if (m_i > LIM1) begin
            band_o = BAND_P2;
        end else if (m_i > ZERO) begin
            band_o = BAND_P1;
        end else if (m_i >= -LIM1) begin
            band_o = BAND_N1;
        end else if (m_i >= -LIM2) begin
            band_o = BAND_N2;
        end else begin
            band_o = BAND_N3;
        end
    end

    // R3: sign of the sample decides the band family, zero goes negative
    assert_band_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        band_is_pos(band_o) == (m_i > ZERO));

endmodule

// File: rtl/lspwm_arm_router.sv
module lspwm_arm_router
    import lspwm_pkg::*;
(
    input  cfg_e                  cfg_i,
    input  band_e                 band_i,
    input  logic [NUM_LAYERS-1:0] up_i,
    input  logic [NUM_LAYERS-1:0] dn_i,
    input  logic                  ps_l_i,
    input  logic                  ps_r_i,
    output logic [NUM_ARMS-1:0]   arm_o
);

    logic       pos;
    logic [1:0] depth;
    logic       dbl_l, dbl_r, sgl_l, sgl_r;

    always_comb begin
        pos   = band_is_pos(band_i);
        depth = band_depth(band_i);

        // two-source cell: conducts fully except in the innermost bands
        dbl_l = pos;
        dbl_r = pos ? (depth != 2'd0) : (depth == 2'd0);

        // single cell fills in between the coarse steps
        sgl_l = pos ? up_i[depth] : (depth == 2'd1);
        sgl_r = pos ? (depth != 2'd1) : dn_i[depth];

        arm_o = '0;
        case (cfg_i)
            CFG_HEALTHY: begin
                for (int k = 0; k < NUM_CELLS; k++) begin
                    arm_o[2*k]   = up_i[k];
                    arm_o[2*k+1] = dn_i[k];
                end
            end
            CFG_MIXED: begin
                arm_o[2*CELL_DBL]   = dbl_l;
                arm_o[2*CELL_DBL+1] = dbl_r;
                arm_o[2*CELL_SGL]   = sgl_l;
                arm_o[2*CELL_SGL+1] = sgl_r;
            end
            CFG_SUBST: begin
                arm_o[2*CELL_DBL]   = dbl_l;
                arm_o[2*CELL_DBL+1] = 1'b0;
                arm_o[2*CELL_BYP]   = 1'b1;
                arm_o[2*CELL_BYP+1] = dbl_r;
                arm_o[2*CELL_SGL]   = sgl_l;
                arm_o[2*CELL_SGL+1] = sgl_r;
            end
            default: begin
                arm_o[2*CELL_DBL]   = ps_l_i;
                arm_o[2*CELL_DBL+1] = ps_r_i;
            end
        endcase
    end

endmodule

// File: rtl/lspwm_region_sel.sv
module lspwm_region_sel
    import lspwm_pkg::*;
#(
    parameter int AC    = 5000,
    parameter int MOD_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [MOD_W-1:0]    mod_in,
    input  logic        [1:0]          cfg_in,
    output logic        [NUM_ARMS-1:0] gate_hi,
    output logic        [NUM_ARMS-1:0] gate_lo
);

    localparam int CW = $clog2(AC + 1);
    localparam int EW = MOD_W + CW + 4;

    typedef struct packed {
        logic [EW-1:0]       m;
        cfg_e                cfg;
        logic [NUM_ARMS-1:0] gate;
    } sel_t;

    sel_t st_d, st_q;

    logic [CW-1:0]         car;
    logic                  peak;
    logic [NUM_LAYERS-1:0] up_cmp, dn_cmp;
    logic                  ps_l, ps_r;
    band_e                 band;
    logic [NUM_ARMS-1:0]   arm;
    logic signed [EW-1:0]  m_s;

    assign m_s = $signed(st_q.m);

    lspwm_carrier #(.AC(AC), .CW(CW)) u_carrier (
        .clk    (clk),
        .rst_n  (rst_n),
        .car_o  (car),
        .peak_o (peak)
    );

    lspwm_layer_cmp #(.AC(AC), .CW(CW), .EW(EW), .NL(NUM_LAYERS)) u_cmp (
        .car_i  (car),
        .m_i    (m_s),
        .up_o   (up_cmp),
        .dn_o   (dn_cmp),
        .ps_l_o (ps_l),
        .ps_r_o (ps_r)
    );

    lspwm_band_cls #(.AC(AC), .EW(EW)) u_band (
        .clk    (clk),
        .rst_n  (rst_n),
        .m_i    (m_s),
        .band_o (band)
    );

    lspwm_arm_router u_router (
        .cfg_i  (st_q.cfg),
        .band_i (band),
        .up_i   (up_cmp),
        .dn_i   (dn_cmp),
        .ps_l_i (ps_l),
        .ps_r_i (ps_r),
        .arm_o  (arm)
    );

    always_comb begin
        st_d      = st_q;
        st_d.gate = arm;
        if (peak) begin
            st_d.m   = EW'(mod_in);
            st_d.cfg = cfg_e'(cfg_in);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{m: '0, cfg: CFG_HEALTHY, gate: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_hi = st_q.gate;
    assign gate_lo = ~st_q.gate;

    // R2: held sample and code only move at the carrier peak
    assert_hold_between_peaks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !peak |=> ($stable(st_q.m) && $stable(st_q.cfg)));

    // R5: bypassed cell idles in the mixed wiring
    assert_bypass_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg == CFG_MIXED) |=> (gate_hi[2*CELL_BYP+1:2*CELL_BYP] == 2'b00));

    // R5: two-source cell left arm follows the sample sign
    assert_dbl_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg == CFG_MIXED) |=> (gate_hi[2*CELL_DBL] == ($past(m_s) > 0)));

    // R7: substitute wiring pins the broken arm low and the borrowed arm high
    assert_subst_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg == CFG_SUBST) |=> (!gate_hi[2*CELL_DBL+1] && gate_hi[2*CELL_BYP]));

    // R8: only cell 0 switches in the triple wiring
    assert_triple_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg == CFG_TRIPLE) |=> (gate_hi[NUM_ARMS-1:2] == '0));

endmodule

// File: tb/lspwm_region_sel_bench.sv
module lspwm_region_sel_bench;

    localparam int AC    = 10;
    localparam int MOD_W = 16;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic signed [MOD_W-1:0] mod_in = '0;
    logic        [1:0]       cfg_in = 2'd0;
    logic        [5:0]       gate_hi, gate_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit armed = 1'b0;

    // behavioural model state
    int   mc = 0;
    bit   mdown = 1'b0;
    int   mm = 0;
    int   mcfg = 0;
    logic [5:0] exp_v = '0;
    int   exp_m = 0;
    int   exp_cfg = 0;
    bit   exp_rst = 1'b1;

    always #10 clk = ~clk;

    lspwm_region_sel #(.AC(AC), .MOD_W(MOD_W)) u_lspwm_region_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .mod_in  (mod_in),
        .cfg_in  (cfg_in),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo)
    );

    function automatic logic [5:0] predict(int c, int m, int cfg);
        logic [5:0] v;
        bit pos;
        int d;
        bit up [3];
        bit dn [3];
        bit dl, dr, sl, sr;
        int t;
        pos = (m > 0);
        if (pos) d = (m > 2*AC) ? 2 : ((m > AC) ? 1 : 0);
        else     d = (m < -2*AC) ? 2 : ((m < -AC) ? 1 : 0);
        for (int k = 0; k < 3; k++) begin
            up[k] = (m > k*AC + c);
            dn[k] = (m > -(k*AC + c));
        end
        dl = pos;
        dr = pos ? (d != 0) : (d == 0);
        sl = pos ? up[d] : (d == 1);
        sr = pos ? (d != 1) : dn[d];
        t = 6*c - 3*AC;
        v = '0;
        case (cfg)
            0: v = {dn[2], up[2], dn[1], up[1], dn[0], up[0]};
            1: v = {sr, sl, 1'b0, 1'b0, dr, dl};
            2: v = {sr, sl, dr, 1'b1, 1'b0, dl};
            default: v = {4'b0000, (m > -t), (m > t)};
        endcase
        return v;
    endfunction

    function automatic string tag_of(bit in_rst, int m, int cfg);
        string s;
        if (in_rst) return "R1";
        case (cfg)
            0: s = "R4 healthy";
            1: s = "R5/R6 mixed";
            2: s = "R7 substitute";
            default: s = "R8 triple";
        endcase
        s = {s, " R2 R9"};
        if (m > 3*AC || m < -3*AC || m == 0) s = {s, " R3"};
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mc = 0; mdown = 1'b0; mm = 0; mcfg = 0;
            exp_v = '0; exp_m = 0; exp_cfg = 0; exp_rst = 1'b1;
        end else begin
            exp_v   = predict(mc, mm, mcfg);
            exp_m   = mm;
            exp_cfg = mcfg;
            exp_rst = 1'b0;
            if (mc == AC) begin
                mm   = int'(mod_in);
                mcfg = int'(cfg_in);
            end
            if (!mdown) begin
                mc++;
                if (mc == AC) mdown = 1'b1;
            end else begin
                mc--;
                if (mc == 0) mdown = 1'b0;
            end
        end
        armed = 1'b1;
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (gate_hi !== exp_v) begin
                errors++;
                $display("FAIL %s m=%0d cfg=%0d gate_hi=%b expected=%b",
                         tag_of(exp_rst, exp_m, exp_cfg), exp_m, exp_cfg, gate_hi, exp_v);
            end
            checks++;
            if (gate_lo !== ~gate_hi) begin
                errors++;
                $display("FAIL R10 gate_lo=%b expected=%b", gate_lo, ~gate_hi);
            end
        end
    end

    task automatic drive(input int m, input int cfg, input int n);
        @(negedge clk);
        mod_in = MOD_W'(m);
        cfg_in = cfg[1:0];
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, inputs busy so nothing may leak through
        mod_in = MOD_W'(25);
        cfg_in = 2'd1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R2: changes away from the peak; hold lengths drift across the period
        drive(7, 0, 3);
        drive(-7, 0, 5);
        drive(33, 3, 17);
        // R4 R5 R6 R7 R8: sweep every wiring code
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int m = -37; m <= 37; m += 4) begin
                drive(m, cfg, 23);
            end
        end
        // R3: band edges, zero and saturation under every code
        for (int cfg = 0; cfg < 4; cfg++) begin
            foreach (edge_vals[i]) begin
                drive(edge_vals[i], cfg, 21);
            end
        end
        // R2: short glitch between peaks must leave the arms untouched
        drive(15, 1, 30);
        drive(-25, 2, 2);
        drive(15, 1, 40);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int edge_vals [19] = '{0, 1, -1, 10, 11, -10, -11, 20, 21, -20, -21,
                           30, -30, 31, -31, 45, -45, 200, -200};

endmodule